// File: doc/BRIEF.md
# Multiplexed-Bus Target Port

This block is the target side of a simplified PCI-style bus. Address and data share one 32-bit bus, and command and byte enables share one 4-bit field. On the first clock that the initiator's frame signal goes low, the block captures the address and the command. If the command is one it serves and the address lands inside its local window, it claims the cycle. It then transfers one 32-bit word per completed data phase to or from a local register-file port, applying the active-low byte enables to writes.

Each pad is split into a separate input, output and output-enable signal. Once a burst ends, the block drives its claim and ready strobes inactive for one clock and then releases them. It serves two windows. The memory window is 4 KB and aligned on a 4 KB boundary, set by `MEM_BASE`. The I/O window is 256 bytes, set by `IO_BASE`. Both windows map onto the same word-indexed local port.

Top module: `pcit_target`

## Requirements
- R1: While reset is low and after it is released, with the bus idle, `ctl_oe`, `ad_oe` and `lp_wr` stay 0, and `devsel_n_o` and `trdy_n_o` read 1.
- R2: An address phase with a memory command claims the cycle if the address lies in the 4 KB window at `MEM_BASE`. The memory commands are read 0110, read-multiple 1100, read-line 1110, write 0111 and write-and-invalidate 1111. In the clock after the address phase, `devsel_n_o` and `trdy_n_o` go 0 and `ctl_oe` goes 1.
- R3: An address phase with I/O read 0010 or I/O write 0011 claims the cycle if the address lies in the 256-byte window at `IO_BASE`. The output timing is the same as in R2.
- R4: The reserved encodings 0100, 0101, 1000, 1001 and 1101 are never claimed, even when the address is inside a window. Interrupt acknowledge 0000, special cycle 0001 and configuration 1010 and 1011 are not claimed either. In all these cases `ctl_oe`, `ad_oe` and `lp_wr` stay 0 for the whole transaction.
- R5: A memory command whose address is outside the memory window is not claimed.
- R6: A data phase completes on a clock where `irdy_n_i` and `trdy_n_o` are both 0. On a write, `lp_wr` is 1 in exactly those clocks, with `lp_wdata` equal to `ad_i`. In the same clocks `lp_wbe[i]` equals the inverse of `cbe_n_i[i]`, and only byte i (bits 8i+7..8i) of the word may change.
- R7: During every data-phase clock of a claimed read, `ad_oe` is 1 and `ad_o` carries `lp_rdata` for the current word.
- R8: The first data phase uses word index `addr[11:2]`. The index advances by one word after each completed phase. A wait clock (`irdy_n_i` high) neither advances it nor writes.
- R9: A phase that completes with `frame_n_i` high is the last one. In the next clock, `devsel_n_o` and `trdy_n_o` are 1 with `ctl_oe` still 1. In the clock after that, `ctl_oe` is 0.
- R10: The block claims only on the first clock of a frame. Data words of a transaction that it did not claim are never decoded as addresses, and the block claims again once the bus has gone idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus, pad input |
| ad_o | output | 32 | Address/data bus, pad output (read data) |
| ad_oe | output | 1 | Output enable for `ad_o` |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n_i | input | 1 | Initiator frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| devsel_n_o | output | 1 | Claim strobe, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| ctl_oe | output | 1 | Output enable for the claim and ready strobes |
| lp_addr | output | 10 | Local port word index |
| lp_wr | output | 1 | Local port write strobe |
| lp_wbe | output | 4 | Local port byte write enables, active high |
| lp_wdata | output | 32 | Local port write data |
| lp_rdata | input | 32 | Local port read data |

## Verification
The final-phase detection and a byte-masked write can fall on the same clock. The bench provokes this by ending write bursts on a beat with a sparse enable mask and by placing a wait clock just before that beat. In that clock the scoreboard checks the write strobe, the mask and the word index. It then checks the released-strobe clock and the float clock that follow. A later read burst over the same words compares each merged word against a reference memory that the bench updates from the requirements alone.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_MEMRD,
    CL_MEMWR,
    CL_IORD,
    CL_IOWR
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } tgt_state_e;

  // Served commands map to a class; reserved and unserved codes yield CL_NONE.
  function automatic cmd_class_e classify(input logic [3:0] code);
    cmd_class_e c;
    case (code)
      4'b0110, 4'b1100, 4'b1110: c = CL_MEMRD;
      4'b0111, 4'b1111:          c = CL_MEMWR;
      4'b0010:                   c = CL_IORD;
      4'b0011:                   c = CL_IOWR;
      default:                   c = CL_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
  import pcit_pkg::*;
#(
  parameter logic [31:0] MEM_BASE     = 32'h0001_0000,
  parameter logic [31:0] IO_BASE      = 32'h0000_0C00,
  parameter int          MEM_WIN_BITS = 12,
  parameter int          IO_WIN_BITS  = 8
) (
  input  logic [31:IO_WIN_BITS] addr_hi,
  input  logic [3:0]            cmd,
  output logic                  claim,
  output logic                  is_write
);

  cmd_class_e cls;
  logic       mem_hit;
  logic       io_hit;

  always_comb begin
    cls      = classify(cmd);
    mem_hit  = (addr_hi[31:MEM_WIN_BITS] == MEM_BASE[31:MEM_WIN_BITS]);
    io_hit   = (addr_hi == IO_BASE[31:IO_WIN_BITS]);
    claim    = (((cls == CL_MEMRD) || (cls == CL_MEMWR)) && mem_hit) ||
               (((cls == CL_IORD)  || (cls == CL_IOWR))  && io_hit);
    is_write = (cls == CL_MEMWR) || (cls == CL_IOWR);
  end

endmodule

// File: rtl/pcit_fsm.sv
module pcit_fsm
  import pcit_pkg::*;
#(
  parameter int LP_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic [LP_AW-1:0] start_idx,
  input  logic             claim,
  input  logic             is_write,
  output tgt_state_e       st,
  output logic [LP_AW-1:0] idx_q,
  output logic             wr_q,
  output logic             addr_phase,
  output logic             beat_done
);

  tgt_state_e       st_nx;
  logic [LP_AW-1:0] idx_nx;
  logic             wr_nx;
  logic             frame_q;
  logic             idx_en;

  always_comb begin
    addr_phase = (st == ST_IDLE) && !frame_n_i && frame_q;
    beat_done  = (st == ST_DATA) && !irdy_n_i;
    st_nx      = st;
    case (st)
      ST_IDLE: if (addr_phase) st_nx = claim ? ST_DATA : ST_SKIP;
      ST_DATA: if (beat_done && frame_n_i) st_nx = ST_TURN;
      ST_TURN: st_nx = ST_IDLE;
      ST_SKIP: if (frame_n_i && irdy_n_i) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
    idx_en = addr_phase || beat_done;
    idx_nx = addr_phase ? start_idx : idx_q + LP_AW'(1);
    wr_nx  = addr_phase ? is_write : wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      frame_q <= 1'b1;
      wr_q    <= 1'b0;
    end else begin
      st      <= st_nx;
      frame_q <= frame_n_i;
      wr_q    <= wr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_nx;
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !frame_n_i) |=> (idx_q == $past(idx_q) + LP_AW'(1))); // R8
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && irdy_n_i) |=> $stable(idx_q)); // R8

endmodule

// File: rtl/pcit_target.sv
module pcit_target
  import pcit_pkg::*;
#(
  parameter logic [31:0] MEM_BASE     = 32'h0001_0000,
  parameter logic [31:0] IO_BASE      = 32'h0000_0C00,
  parameter int          MEM_WIN_BITS = 12,
  parameter int          IO_WIN_BITS  = 8,
  localparam int         LP_AW        = MEM_WIN_BITS - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ad_i,
  output logic [31:0]      ad_o,
  output logic             ad_oe,
  input  logic [3:0]       cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  output logic             devsel_n_o,
  output logic             trdy_n_o,
  output logic             ctl_oe,
  output logic [LP_AW-1:0] lp_addr,
  output logic             lp_wr,
  output logic [3:0]       lp_wbe,
  output logic [31:0]      lp_wdata,
  input  logic [31:0]      lp_rdata
);

  tgt_state_e       st;
  logic [LP_AW-1:0] idx_q;
  logic             wr_q;
  logic             addr_phase;
  logic             beat_done;
  logic             claim;
  logic             is_write;
  logic             active;

  pcit_decode #(
    .MEM_BASE    (MEM_BASE),
    .IO_BASE     (IO_BASE),
    .MEM_WIN_BITS(MEM_WIN_BITS),
    .IO_WIN_BITS (IO_WIN_BITS)
  ) u_decode (
    .addr_hi (ad_i[31:IO_WIN_BITS]),
    .cmd     (cbe_n_i),
    .claim   (claim),
    .is_write(is_write)
  );

  pcit_fsm #(.LP_AW(LP_AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n_i (frame_n_i),
    .irdy_n_i  (irdy_n_i),
    .start_idx (ad_i[LP_AW+1:2]),
    .claim     (claim),
    .is_write  (is_write),
    .st        (st),
    .idx_q     (idx_q),
    .wr_q      (wr_q),
    .addr_phase(addr_phase),
    .beat_done (beat_done)
  );

  always_comb begin
    active     = (st == ST_DATA);
    ctl_oe     = active || (st == ST_TURN);
    devsel_n_o = !active;
    trdy_n_o   = !active;
    lp_addr    = idx_q;
    lp_wr      = beat_done && wr_q;
    lp_wbe     = ~cbe_n_i;
    lp_wdata   = ad_i;
    ad_oe      = active && !wr_q;
    ad_o       = lp_rdata;
  end

  logic rsvd_code;
  assign rsvd_code = (cbe_n_i == 4'b0100) || (cbe_n_i == 4'b0101) ||
                     (cbe_n_i == 4'b1000) || (cbe_n_i == 4'b1001) ||
                     (cbe_n_i == 4'b1101);

  AST_RSVD_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && rsvd_code) |=> (devsel_n_o && !ctl_oe)); // R4
  AST_CLAIM_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_o) |-> $past(addr_phase)); // R2
  AST_FINAL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n_o && !irdy_n_i && frame_n_i) |=> (ctl_oe && devsel_n_o && trdy_n_o)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n_o) |=> !ctl_oe); // R9
  AST_WR_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_wr |-> (!trdy_n_o && !irdy_n_i && ctl_oe)); // R6

endmodule

// File: tb/pcit_target_bench.sv
module pcit_target_bench;

  localparam logic [31:0] MEMB = 32'h0001_0000;
  localparam logic [31:0] IOB  = 32'h0000_0C00;

  typedef struct {
    bit          ck_ctl;
    bit          oe;
    bit          dv;
    bit          tr;
    bit          wr;
    logic [3:0]  wbe;
    logic [9:0]  la;
    logic [31:0] wd;
    bit          adoe;
    logic [31:0] ad;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] ad_i;
  logic [31:0] ad_o;
  logic        ad_oe;
  logic [3:0]  cbe_n_i;
  logic        frame_n_i;
  logic        irdy_n_i;
  logic        devsel_n_o;
  logic        trdy_n_o;
  logic        ctl_oe;
  logic [9:0]  lp_addr;
  logic        lp_wr;
  logic [3:0]  lp_wbe;
  logic [31:0] lp_wdata;
  logic [31:0] lp_rdata;

  logic [31:0] mem  [0:1023];
  logic [31:0] gold [0:1023];
  exp_t        q[$];
  int          nvec = 0;
  int          nfail = 0;
  bit          done = 0;

  pcit_target #(.MEM_BASE(MEMB), .IO_BASE(IOB)) u_pcit_target (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .cbe_n_i(cbe_n_i), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o), .ctl_oe(ctl_oe),
    .lp_addr(lp_addr), .lp_wr(lp_wr), .lp_wbe(lp_wbe), .lp_wdata(lp_wdata),
    .lp_rdata(lp_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Local storage seen by the design
  assign lp_rdata = mem[lp_addr];
  always @(posedge clk) begin
    if (lp_wr) begin
      for (int b = 0; b < 4; b++)
        if (lp_wbe[b]) mem[lp_addr][8*b +: 8] <= lp_wdata[8*b +: 8];
    end
  end

  function automatic logic [3:0] be_pat(input int k);
    case (k % 4)
      0: return 4'hF;
      1: return 4'h1;
      2: return 4'h6;
      default: return 4'h8;
    endcase
  endfunction

  function automatic exp_t idle_exp(input string tag);
    exp_t e;
    e.ck_ctl = 1; e.oe = 0; e.dv = 1; e.tr = 1; e.wr = 0;
    e.wbe = 0; e.la = 0; e.wd = 0; e.adoe = 0; e.ad = 0; e.tag = tag;
    return e;
  endfunction

  task automatic cyc(input logic fr, input logic ir, input logic [31:0] ad,
                     input logic [3:0] cb, input exp_t e);
    @(negedge clk);
    frame_n_i = fr; irdy_n_i = ir; ad_i = ad; cbe_n_i = cb;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 32'h0, 4'hF, idle_exp(tag));
  endtask

  // One transaction; claim/wr are the expectations derived from the requirements
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                     input bit claim, input bit wr, input int wait_at,
                     input logic [31:0] data_base, input string tag);
    exp_t e;
    logic [9:0] idx;
    logic [31:0] wd;
    logic [3:0] be;
    idx = addr[11:2];
    cyc(1'b0, 1'b1, addr, cmd, idle_exp(tag));
    for (int k = 0; k < n; k++) begin
      be = be_pat(k);
      wd = data_base + 32'h0101_0101 * k;
      if (k == wait_at) begin
        e = idle_exp(tag);
        if (claim) begin
          e.oe = 1; e.dv = 0; e.tr = 0; e.adoe = !wr; e.ad = gold[idx];
        end
        cyc(1'b0, 1'b1, 32'hDEAD_BEEF, 4'h0, e);
      end
      e = idle_exp(tag);
      if (claim) begin
        e.oe = 1; e.dv = 0; e.tr = 0;
        e.wr = wr; e.wbe = be; e.la = idx; e.wd = wd;
        e.adoe = !wr; e.ad = gold[idx];
      end
      cyc((k == n - 1), 1'b0, wr ? wd : data_base, ~be, e);
      if (claim && wr) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) gold[idx][8*b +: 8] = wd[8*b +: 8];
      end
      if (claim) idx = idx + 10'd1;
    end
    if (claim) begin
      e = idle_exp(tag); e.oe = 1;
      cyc(1'b1, 1'b1, 32'h0, 4'hF, e);
    end
    idle(2, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per clock and compares
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() != 0) begin
        e = q.pop_front();
        cmp(e.tag, "ctl_oe", {31'b0, ctl_oe}, {31'b0, e.oe});
        if (e.oe) cmp(e.tag, "devsel/trdy", {30'b0, devsel_n_o, trdy_n_o}, {30'b0, e.dv, e.tr});
        cmp(e.tag, "lp_wr", {31'b0, lp_wr}, {31'b0, e.wr});
        if (e.wr) begin
          cmp(e.tag, "lp_wbe", {28'b0, lp_wbe}, {28'b0, e.wbe});
          cmp(e.tag, "lp_addr", {22'b0, lp_addr}, {22'b0, e.la});
          cmp(e.tag, "lp_wdata", lp_wdata, e.wd);
        end
        cmp(e.tag, "ad_oe", {31'b0, ad_oe}, {31'b0, e.adoe});
        if (e.adoe) cmp(e.tag, "ad_o", ad_o, e.ad);
      end
    end
  end

  // Watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 32'h1000_0000 + i * 32'h0003_0007;
      gold[i] = 32'h1000_0000 + i * 32'h0003_0007;
    end
    rst_n = 1'b0; frame_n_i = 1'b1; irdy_n_i = 1'b1; ad_i = '0; cbe_n_i = 4'hF;
    // R1: outputs floated during reset
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 32'h0, 4'hF, idle_exp("R1"));
    @(negedge clk); rst_n = 1'b1; q.push_back(idle_exp("R1"));
    idle(2, "R1");
    // R2 R6 R8 R9: memory write burst, wait before last beat
    txn(4'b0111, MEMB + 32'h10, 4, 1, 1, 3, 32'hA1B2_C3D4, "R6");
    // R7 R8: read back merged words with a wait state
    txn(4'b1100, MEMB + 32'h10, 4, 1, 0, 1, 32'h0, "R7");
    // R2: write-and-invalidate, read-line, plain read
    txn(4'b1111, MEMB + 32'hFFC, 2, 1, 1, -1, 32'h5566_7788, "R2");
    txn(4'b1110, MEMB + 32'hFFC, 2, 1, 0, -1, 32'h0, "R2");
    txn(4'b0110, MEMB + 32'h40, 1, 1, 0, 0, 32'h0, "R9");
    // R3: I/O window
    txn(4'b0011, IOB + 32'h4, 1, 1, 1, -1, 32'h0BAD_F00D, "R3");
    txn(4'b0010, IOB + 32'h4, 2, 1, 0, -1, 32'h0, "R3");
    txn(4'b0011, MEMB + 32'h4, 1, 0, 1, -1, 32'h1111_1111, "R3");
    // R4: reserved and unserved commands inside the window
    txn(4'b0100, MEMB + 32'h20, 2, 0, 1, -1, 32'h2222_2222, "R4");
    txn(4'b0101, MEMB + 32'h20, 1, 0, 1, -1, 32'h2222_2222, "R4");
    txn(4'b1000, MEMB + 32'h20, 1, 0, 1, -1, 32'h2222_2222, "R4");
    txn(4'b1001, MEMB + 32'h20, 1, 0, 1, -1, 32'h2222_2222, "R4");
    txn(4'b1101, MEMB + 32'h20, 1, 0, 1, -1, 32'h2222_2222, "R4");
    txn(4'b1010, MEMB + 32'h20, 1, 0, 0, -1, 32'h0, "R4");
    txn(4'b0001, MEMB + 32'h20, 1, 0, 1, -1, 32'h0, "R4");
    // R5: outside the memory window
    txn(4'b0111, MEMB + 32'h1000, 2, 0, 1, -1, 32'h3333_3333, "R5");
    txn(4'b0110, MEMB - 32'h4, 1, 0, 0, -1, 32'h0, "R5");
    // R10: unclaimed burst whose data words look like in-window addresses
    txn(4'b0111, 32'h0002_0000, 3, 0, 1, 1, MEMB + 32'h10, "R10");
    // R10 R4: confirm nothing reserved leaked into storage, then claim again
    txn(4'b0110, MEMB + 32'h20, 2, 1, 0, -1, 32'h0, "R10");
    txn(4'b1100, MEMB + 32'h10, 4, 1, 0, -1, 32'h0, "R10");
    idle(3, "R1");
    @(negedge clk);
    #8;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule